// File: doc/BRIEF.md
# Saturating Wiper Position Counter

This block keeps the tap position of a 100-step resistor ladder as a 7-bit value from 0 (low end) to 100 (high end). The serial command decoder drives it with three kinds of update. A direct load writes a new position. A transfer takes the position field of a memory word. Step strobes move the tap by one position per clock, up or down. The current position goes to the tap decoder and to the serial read path.

After reset, which stands in for power-on, the block waits a parameterized number of cycles. It then reads memory word 0 through a one-cycle-latency read port and sets the position from the seven low bits of that word. If those bits are above the top of the ladder, the recall sets mid-scale (50) instead. From that point on, `ready` stays high. The block ignores every command from reset until `ready` rises.

Top module: `wiper_counter`

## Requirements
- R1: While reset is high and in the cycle after it falls, `wiper_pos` is 0, `ready` is 0 and `mem_rd_en` is 0.
- R2: With `DELAY_CYCLES` = D, `mem_rd_en` goes high for exactly one cycle, with `mem_rd_addr` = 0. This happens after the (D+1)-th rising edge following reset release. `ready` is first high after the (D+3)-th edge and then stays high until the next reset.
- R3: The recall uses bits [6:0] of the returned word, and bits [15:7] have no effect. A value of 0..100 becomes the position. A value of 101..127 sets the position to 50.
- R4: Before `ready` is high, `load_en`, `xfer_en` and `step_en` have no effect on `wiper_pos`.
- R5: A cycle with `load_en` high sets `wiper_pos` from `load_val` at the next edge, and any value above 100 becomes 100.
- R6: A cycle with `xfer_en` high sets `wiper_pos` from `xfer_word[14:8]` at the next edge, and any value above 100 becomes 100. Bit 15 and bits [7:0] have no effect.
- R7: Each cycle with `step_en` and `step_up` high adds one to `wiper_pos`. At 100 the step is ignored.
- R8: Each cycle with `step_en` high and `step_up` low subtracts one from `wiper_pos`. At 0 the step is ignored.
- R9: When several commands arrive in the same cycle, a load takes priority over a transfer, and a transfer takes priority over a step.
- R10: `wiper_pos` never exceeds 100. Once `ready` is high, a cycle with no command leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| load_en | input | 1 | Direct position load strobe |
| load_val | input | 7 | Position for direct load |
| xfer_en | input | 1 | Memory-word transfer strobe |
| xfer_word | input | 16 | Memory word whose bits [14:8] hold the position |
| step_en | input | 1 | One-position step strobe |
| step_up | input | 1 | Step direction: 1 toward high end, 0 toward low end |
| mem_rd_en | output | 1 | Recall read request |
| mem_rd_addr | output | 7 | Recall read address (always 0) |
| mem_rd_data | input | 16 | Read data, valid the cycle after the request |
| ready | output | 1 | Recall finished; commands accepted |
| wiper_pos | output | 7 | Current tap position |

## Verification
A recall state that is wrong shows up at once in the timing of `mem_rd_en` and `ready`, which are compared against the exact edge counts of R2. A wrong saturation or clamp shows in `wiper_pos` one edge after the command. The bench therefore samples after every single update, not only at the end of a sequence. A priority or holdoff fault leaves a position that differs from the recalled or highest-priority value in the very next cycle. The recall substitution shows one edge after `ready` rises, through the R3 values chosen at the boundary: 100, 101, 127 and a word with bit 7 set.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    localparam int POS_BITS = 7;

    typedef logic [POS_BITS-1:0] pos_t;

    typedef enum logic [1:0] {
        RC_WAIT,
        RC_READ,
        RC_CAPTURE,
        RC_DONE
    } rc_state_e;

    typedef enum logic [2:0] {
        SRC_HOLD,
        SRC_RECALL,
        SRC_LOAD,
        SRC_XFER,
        SRC_INC,
        SRC_DEC
    } src_e;

    typedef struct packed {
        src_e src;
        pos_t val;
    } upd_t;

    // Saturate a raw 7-bit value to the top tap.
    function automatic pos_t clamp_top(pos_t v, pos_t top);
        return (v > top) ? top : v;
    endfunction

    // Recall rule: out-of-range stored value maps to mid-scale.
    function automatic pos_t recall_fix(pos_t v, pos_t top, pos_t mid);
        return (v > top) ? mid : v;
    endfunction

endpackage

// File: rtl/wpc_por_timer.sv
module wpc_por_timer #(
    parameter int DELAY_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst,
    output logic delay_done
);
    localparam int CNT_W = $clog2(DELAY_CYCLES + 1) + 1;
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DELAY_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign delay_done = (cnt_q == LIMIT);

endmodule

// File: rtl/wpc_recall.sv
module wpc_recall #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              capture,
    output logic              ready
);
    import wpc_pkg::*;

    rc_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RC_WAIT:    if (start) state_d = RC_READ;
            RC_READ:    state_d = RC_CAPTURE;
            RC_CAPTURE: state_d = RC_DONE;
            RC_DONE:    state_d = RC_DONE;
            default:    state_d = RC_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= RC_WAIT;
        else     state_q <= state_d;
    end

    assign rd_en   = (state_q == RC_READ);
    assign rd_addr = '0;
    assign capture = (state_q == RC_CAPTURE);
    assign ready   = (state_q == RC_DONE);

endmodule

// File: rtl/wpc_cmd_arb.sv
module wpc_cmd_arb #(
    parameter int WORD_W   = 16,
    parameter int XFER_LSB = 8,
    parameter int POS_MAX  = 100,
    parameter int POS_MID  = 50
) (
    input  logic              ready,
    input  logic              capture,
    input  logic [WORD_W-1:0] rd_data,
    input  logic              load_en,
    input  wpc_pkg::pos_t     load_val,
    input  logic              xfer_en,
    input  logic [WORD_W-1:0] xfer_word,
    input  logic              step_en,
    input  logic              step_up,
    input  wpc_pkg::pos_t     cur_pos,
    output wpc_pkg::upd_t     upd
);
    import wpc_pkg::*;

    localparam pos_t TOP = pos_t'(POS_MAX);
    localparam pos_t MID = pos_t'(POS_MID);

    pos_t recall_raw;
    pos_t xfer_raw;

    assign recall_raw = rd_data[POS_BITS-1:0];
    assign xfer_raw   = xfer_word[XFER_LSB +: POS_BITS];

    always_comb begin
        upd.src = SRC_HOLD;
        upd.val = cur_pos;
        if (capture) begin
            upd.src = SRC_RECALL;
            upd.val = recall_fix(recall_raw, TOP, MID);
        end else if (ready) begin
            if (load_en) begin
                upd.src = SRC_LOAD;
                upd.val = clamp_top(load_val, TOP);
            end else if (xfer_en) begin
                upd.src = SRC_XFER;
                upd.val = clamp_top(xfer_raw, TOP);
            end else if (step_en && step_up) begin
                if (cur_pos < TOP) begin
                    upd.src = SRC_INC;
                    upd.val = cur_pos + 1'b1;
                end
            end else if (step_en && !step_up) begin
                if (cur_pos != '0) begin
                    upd.src = SRC_DEC;
                    upd.val = cur_pos - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/wpc_pos_reg.sv
module wpc_pos_reg (
    input  logic          clk,
    input  logic          rst,
    input  wpc_pkg::upd_t upd,
    output wpc_pkg::pos_t pos
);
    import wpc_pkg::*;

    pos_t pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (upd.src != SRC_HOLD) begin
            pos_q <= upd.val;
        end
    end

    assign pos = pos_q;

endmodule

// File: rtl/wiper_counter.sv
module wiper_counter #(
    parameter int WORD_W       = 16,
    parameter int ADDR_W       = 7,
    parameter int XFER_LSB     = 8,
    parameter int POS_MAX      = 100,
    parameter int POS_MID      = 50,
    parameter int DELAY_CYCLES = 500000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [6:0]        load_val,
    input  logic              xfer_en,
    input  logic [WORD_W-1:0] xfer_word,
    input  logic              step_en,
    input  logic              step_up,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              ready,
    output logic [6:0]        wiper_pos
);
    import wpc_pkg::*;

    logic delay_done;
    logic capture;
    upd_t upd;
    pos_t pos;

    wpc_por_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .delay_done (delay_done)
    );

    wpc_recall #(.ADDR_W(ADDR_W)) u_recall (
        .clk     (clk),
        .rst     (rst),
        .start   (delay_done),
        .rd_en   (mem_rd_en),
        .rd_addr (mem_rd_addr),
        .capture (capture),
        .ready   (ready)
    );

    wpc_cmd_arb #(
        .WORD_W   (WORD_W),
        .XFER_LSB (XFER_LSB),
        .POS_MAX  (POS_MAX),
        .POS_MID  (POS_MID)
    ) u_arb (
        .ready     (ready),
        .capture   (capture),
        .rd_data   (mem_rd_data),
        .load_en   (load_en),
        .load_val  (load_val),
        .xfer_en   (xfer_en),
        .xfer_word (xfer_word),
        .step_en   (step_en),
        .step_up   (step_up),
        .cur_pos   (pos),
        .upd       (upd)
    );

    wpc_pos_reg u_pos (
        .clk (clk),
        .rst (rst),
        .upd (upd),
        .pos (pos)
    );

    assign wiper_pos = pos;

endmodule

// File: rtl/wpc_checker.sv
module wpc_checker #(
    parameter int ADDR_W  = 7,
    parameter int POS_MAX = 100
) (
    input logic              clk,
    input logic              rst,
    input logic              load_en,
    input logic [6:0]        load_val,
    input logic              xfer_en,
    input logic              step_en,
    input logic              step_up,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              ready,
    input logic [6:0]        wiper_pos
);
    localparam logic [6:0] TOP = 7'(POS_MAX);

    // R10
    pos_range_chk: assert property (@(posedge clk) disable iff (rst)
        wiper_pos <= TOP);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && !load_en && !xfer_en && !step_en) |=> $stable(wiper_pos));

    // R7
    step_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && step_en && step_up && !load_en && !xfer_en && wiper_pos < TOP)
        |=> wiper_pos == $past(wiper_pos) + 7'd1);

    // R8
    step_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && step_en && !step_up && !load_en && !xfer_en && wiper_pos != 7'd0)
        |=> wiper_pos == $past(wiper_pos) - 7'd1);

    // R5
    load_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && load_en) |=>
        wiper_pos == (($past(load_val) > TOP) ? TOP : $past(load_val)));

    // R2
    rd_addr_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> mem_rd_addr == '0);

    // R2
    ready_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(mem_rd_en, 2));

    // R2
    ready_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

    // R2
    single_read_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en);

endmodule

bind wiper_counter wpc_checker #(.ADDR_W(ADDR_W), .POS_MAX(POS_MAX)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .load_en     (load_en),
    .load_val    (load_val),
    .xfer_en     (xfer_en),
    .step_en     (step_en),
    .step_up     (step_up),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .ready       (ready),
    .wiper_pos   (wiper_pos)
);

// File: tb/tb_wiper_counter.sv
module tb_wiper_counter;

    localparam int D = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_en = 1'b0;
    logic [6:0]  load_val = '0;
    logic        xfer_en = 1'b0;
    logic [15:0] xfer_word = '0;
    logic        step_en = 1'b0;
    logic        step_up = 1'b0;
    logic        mem_rd_en;
    logic [6:0]  mem_rd_addr;
    logic [15:0] mem_rd_data = '0;
    logic        ready;
    logic [6:0]  wiper_pos;

    logic [15:0] word0 = '0;
    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wiper_counter #(.DELAY_CYCLES(D)) dut (
        .clk         (clk),
        .rst         (rst),
        .load_en     (load_en),
        .load_val    (load_val),
        .xfer_en     (xfer_en),
        .xfer_word   (xfer_word),
        .step_en     (step_en),
        .step_up     (step_up),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data),
        .ready       (ready),
        .wiper_pos   (wiper_pos)
    );

    // Memory read port: one-cycle latency, word 0 programmable.
    always_ff @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= (mem_rd_addr == 7'd0) ? word0 : 16'hDEAD;
    end

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_cmds();
        load_en = 1'b0; xfer_en = 1'b0; step_en = 1'b0; step_up = 1'b0;
    endtask

    // Reset with a given word 0, check reset state and recall timing.
    task automatic t_reset_recall(input logic [15:0] w, input int exp_pos);
        int rd_seen;
        @(negedge clk);
        word0 = w;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 pos in reset", wiper_pos, 0);
        check("R1 ready in reset", ready, 0);
        check("R1 rd_en in reset", mem_rd_en, 0);
        rst = 1'b0;
        rd_seen = 0;
        for (int e = 1; e <= D + 3; e++) begin
            @(negedge clk);
            if (e == 1) begin
                check("R1 pos after release", wiper_pos, 0);
                check("R1 ready after release", ready, 0);
            end
            if (mem_rd_en) begin
                rd_seen++;
                check("R2 read cycle", e, D + 1);
                check("R2 read addr", mem_rd_addr, 0);
            end
            if (e == D + 2) check("R2 ready not early", ready, 0);
        end
        check("R2 single read", rd_seen, 1);
        check("R2 ready on time", ready, 1);
        check("R3 recall value", wiper_pos, exp_pos);
        @(negedge clk);
        check("R2 ready stays", ready, 1);
    endtask

    task automatic t_holdoff();
        @(negedge clk);
        word0 = 16'h0021;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        load_en = 1'b1; load_val = 7'd77;
        xfer_en = 1'b1; xfer_word = 16'h0500;
        step_en = 1'b1; step_up = 1'b1;
        for (int e = 1; e <= D + 2; e++) begin
            @(negedge clk);
            if (e == D) check("R4 pos before ready", wiper_pos, 0);
        end
        clear_cmds();
        @(negedge clk);
        check("R4 ready", ready, 1);
        check("R4 recalled value kept", wiper_pos, 33);
    endtask

    task automatic do_load(input int v, input int exp, input string req);
        load_en = 1'b1; load_val = 7'(v);
        @(negedge clk);
        clear_cmds();
        check(req, wiper_pos, exp);
    endtask

    task automatic t_load();
        do_load(0, 0, "R5 load 0");
        do_load(100, 100, "R5 load 100");
        do_load(101, 100, "R5 load 101 clamp");
        do_load(127, 100, "R5 load 127 clamp");
        do_load(42, 42, "R5 load 42");
    endtask

    task automatic do_xfer(input logic [15:0] w, input int exp, input string req);
        xfer_en = 1'b1; xfer_word = w;
        @(negedge clk);
        clear_cmds();
        check(req, wiper_pos, exp);
    endtask

    task automatic t_xfer();
        do_xfer(16'h45AB, 69, "R6 xfer field");
        do_xfer(16'h7F00, 100, "R6 xfer clamp");
        do_xfer(16'hB2FF, 50, "R6 xfer ignores bit15 and low byte");
        do_xfer(16'h6500, 100, "R6 xfer 101 clamp");
    endtask

    task automatic t_step_up();
        do_load(98, 98, "R7 preset");
        step_en = 1'b1; step_up = 1'b1;
        @(negedge clk); check("R7 step 98->99", wiper_pos, 99);
        @(negedge clk); check("R7 step 99->100", wiper_pos, 100);
        @(negedge clk); check("R7 saturate at 100", wiper_pos, 100);
        @(negedge clk); check("R7 saturate again", wiper_pos, 100);
        clear_cmds();
    endtask

    task automatic t_step_down();
        do_load(2, 2, "R8 preset");
        step_en = 1'b1; step_up = 1'b0;
        @(negedge clk); check("R8 step 2->1", wiper_pos, 1);
        @(negedge clk); check("R8 step 1->0", wiper_pos, 0);
        @(negedge clk); check("R8 saturate at 0", wiper_pos, 0);
        clear_cmds();
    endtask

    task automatic t_priority();
        do_load(60, 60, "R9 preset");
        load_en = 1'b1; load_val = 7'd10;
        xfer_en = 1'b1; xfer_word = 16'h2000;
        step_en = 1'b1; step_up = 1'b1;
        @(negedge clk);
        clear_cmds();
        check("R9 load wins", wiper_pos, 10);
        xfer_en = 1'b1; xfer_word = 16'h2000;
        step_en = 1'b1; step_up = 1'b0;
        @(negedge clk);
        clear_cmds();
        check("R9 xfer beats step", wiper_pos, 32);
    endtask

    task automatic t_hold();
        do_load(57, 57, "R10 preset");
        load_val = 7'd3; xfer_word = 16'h0100; step_up = 1'b1;
        for (int i = 0; i < 5; i++) @(negedge clk);
        check("R10 idle hold", wiper_pos, 57);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset_recall(16'h0040, 64);
        t_reset_recall(16'h0064, 100);
        t_reset_recall(16'h00E5, 50);
        t_reset_recall(16'h007F, 50);
        t_reset_recall(16'hFF80, 0);
        t_holdoff();
        t_load();
        t_xfer();
        t_step_up();
        t_step_down();
        t_priority();
        t_hold();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule